// File: doc/BRIEF.md
# SPI Master with Per-Entry Control Queue

This block is a full-duplex SPI master. Software queues 32-bit words into an 8-entry transmit FIFO. Each word holds a data field of up to 16 bits and a control field that travels with it: the frame width, which select lines to drive and whether the transaction ends after this frame. The only event that starts a frame is a word reaching the shift engine from the transmit FIFO. While the engine shifts the word out on MOSI, it samples MISO on the opposite clock edges. At the end of the frame the received bits are pushed, right-aligned, into an 8-entry receive FIFO. Reading that FIFO never produces SCK activity.

Select lines keep their state from one queued entry to the next, so several entries can form one transaction. All lines are released only after an entry that carries the end-of-transfer flag. A control register sets clock polarity, clock phase, the SCK divider, two FIFO watermarks and two level-interrupt enables. A status register shows the FIFO states and a sticky receive-overrun flag.

The register port is a single-cycle strobe port with no back-pressure. Software uses the not-full and not-empty status bits for flow control. A write to a full transmit FIFO is discarded. A read from an empty receive FIFO returns zero and changes nothing.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, SCK is 0 and every select line is high. The status register (offset 0xE04) reads 0x12: bit 4 is transmit-empty and bit 1 is transmit-not-full. The control register (offset 0xE00) reads 0x0010_0100: polarity 0, phase 0, divider 1 in bits 15:8, transmit watermark 0 in bits 19:16, receive watermark 1 in bits 23:20, both interrupt enables off.
- R2: A write to offset 0xE20 queues an entry, and the entry launches a frame of code+1 bits. The code is bits 27:24. The frame shifts data bits 15:0 MSB first and produces 2·(code+1) SCK transitions, each separated by divider+1 clock cycles.
- R3: MISO is sampled during the same frame. The received word reads at offset 0xE30 right-aligned in bits 15:0, with all unused upper bits zero.
- R4: Reading offset 0xE30 pops the receive FIFO and never causes an SCK transition. A read of an empty receive FIFO returns 0.
- R5: Bits 19:16 of an entry give one deassert bit per select line, ssel_n[3:0]. Each line whose bit is 0 is driven low for that frame.
- R6: An entry with bit 20 set drives all select lines high after its last bit. An entry without bit 20 leaves the select lines unchanged after it, until the next entry starts.
- R7: Control bit 0 sets the SCK idle level. Control bit 1 set to 0 samples MISO on the leading edge of each bit; set to 1, it samples on the trailing edge. SCK stays at the idle level whenever no frame is active.
- R8: Status bit 4 becomes 1 only after the last queued frame has fully shifted, and by then its received word is already in the receive FIFO (status bit 2 set).
- R9: Output irq_tx is high when control bit 24 is set and the transmit FIFO level is at or below the transmit watermark. Output irq_rx is high when control bit 25 is set and the receive FIFO level is at or above the receive watermark.
- R10: Both FIFOs hold 8 entries. A frame that completes while the receive FIFO is full is dropped and sets sticky status bit 3. Writing 1 to status bit 3 clears it.
- R11: A write to offset 0xE20 while the transmit FIFO is full (status bit 1 = 0) is discarded and launches no frame.
- R12: Length codes 0 to 2 are treated as code 3, which gives a 4-bit frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_en is high |
| irq_tx | output | 1 | Transmit-level interrupt request |
| irq_rx | output | 1 | Receive-level interrupt request |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel_n | output | 4 | Active-low select lines |

## Verification
Two receive FIFO operations can fall in the same clock cycle: the shift engine pushing a completed frame, and software popping the receive FIFO. The bench first leaves one word waiting in the receive FIFO. It then starts a frame with divider 1 and an 8-bit length, and counts cycles so that its read strobe covers exactly the cycle in which that frame completes. The check passes when the read returns the older word, the next read returns the new frame's word, and a third read finds the FIFO empty with no overrun flag set.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int NUM_SEL = 4;

  localparam logic [11:0] OFF_CTRL = 12'hE00;
  localparam logic [11:0] OFF_STAT = 12'hE04;
  localparam logic [11:0] OFF_TXW  = 12'hE20;
  localparam logic [11:0] OFF_RXR  = 12'hE30;

  localparam int ENT_DESEL_LSB = 16;
  localparam int ENT_EOT_BIT   = 20;
  localparam int ENT_LEN_LSB   = 24;

  localparam int STAT_TXNF = 1;
  localparam int STAT_RXNE = 2;
  localparam int STAT_OVR  = 3;
  localparam int STAT_TXE  = 4;

  localparam logic [3:0] MIN_LEN_CODE = 4'd3;

  typedef struct packed {
    logic                eot;
    logic [NUM_SEL-1:0]  desel;
    logic [3:0]          len;
    logic [15:0]         data;
  } tx_entry_t;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == CW'(DEPTH)));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> (count == '0));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_fifo_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [DIV_W-1:0]   div,
  input  logic               ent_valid,
  input  tx_entry_t          ent,
  output logic               ent_pop,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [NUM_SEL-1:0] ssel_n,
  output logic               busy,
  output logic               done,
  output logic [15:0]        rx_word
);
  logic [DIV_W-1:0] cnt;
  logic [4:0]       edge_idx;
  logic [4:0]       ptr;
  logic [3:0]       len_q, len_in;
  logic [15:0]      tx_sh, rx_sh;
  logic             ph, cpol_q, cpha_q, eot_q, last, tick;

  assign len_in  = (ent.len < MIN_LEN_CODE) ? MIN_LEN_CODE : ent.len;
  assign ent_pop = !busy && ent_valid;
  assign tick    = busy && (cnt == div);
  assign last    = (edge_idx == {len_q, 1'b1});
  assign done    = tick && last;
  assign sck     = busy ? (cpol_q ^ ph) : cpol;
  assign rx_word = cpha_q ? {rx_sh[14:0], miso} : rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      edge_idx <= '0;
      ptr      <= '0;
      len_q    <= MIN_LEN_CODE;
      tx_sh    <= '0;
      rx_sh    <= '0;
      ph       <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      eot_q    <= 1'b0;
      mosi     <= 1'b0;
      ssel_n   <= '1;
    end else if (!busy) begin
      if (ent_valid) begin
        busy     <= 1'b1;
        cnt      <= '0;
        edge_idx <= '0;
        ph       <= 1'b0;
        len_q    <= len_in;
        tx_sh    <= ent.data;
        rx_sh    <= '0;
        cpol_q   <= cpol;
        cpha_q   <= cpha;
        eot_q    <= ent.eot;
        ssel_n   <= ent.desel;
        if (!cpha) begin
          mosi <= ent.data[len_in];
          ptr  <= {1'b0, len_in} - 5'd1;
        end else begin
          ptr  <= {1'b0, len_in};
        end
      end
    end else if (tick) begin
      cnt      <= '0;
      ph       <= ~ph;
      edge_idx <= edge_idx + 5'd1;
      if (edge_idx[0] == cpha_q) begin
        rx_sh <= {rx_sh[14:0], miso};
      end else if (!ptr[4]) begin
        mosi <= tx_sh[ptr[3:0]];
        ptr  <= ptr - 5'd1;
      end
      if (last) begin
        busy <= 1'b0;
        ph   <= 1'b0;
        if (eot_q) ssel_n <= '1;
      end
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  assert_idle_sck_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));
  assert_start_from_queue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ent_valid));
  assert_release_on_eot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && eot_q) |=> (ssel_n == '1));
  assert_hold_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ent_valid) |=> $stable(ssel_n));
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8,
  parameter int DIV_RESET  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_tx,
  output logic        irq_rx,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  ssel_n
);
  localparam int CW    = $clog2(FIFO_DEPTH + 1);
  localparam int ENT_W = $bits(tx_entry_t);

  logic             cfg_cpol, cfg_cpha, cfg_txen, cfg_rxen, ovr;
  logic [DIV_W-1:0] cfg_div;
  logic [3:0]       cfg_txwm, cfg_rxwm;

  logic             wr, rd, tx_push, tx_pop, rx_push, rx_pop;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0]    tx_count, rx_count;
  tx_entry_t        ent_in, ent_out;
  logic [ENT_W-1:0] ent_raw;
  logic [15:0]      rx_head, rx_word;
  logic             eng_busy, eng_done, stat_txe;
  logic [31:0]      ctrl_rd, stat_rd;
  logic             wdata_unused;

  assign wr      = bus_en && bus_we;
  assign rd      = bus_en && !bus_we;
  assign tx_push = wr && (bus_addr == OFF_TXW);
  assign rx_pop  = rd && (bus_addr == OFF_RXR);
  assign rx_push = eng_done;
  assign wdata_unused = ^{bus_wdata[31:28], bus_wdata[23:21]};

  assign ent_in.data  = bus_wdata[15:0];
  assign ent_in.desel = bus_wdata[ENT_DESEL_LSB +: NUM_SEL];
  assign ent_in.eot   = bus_wdata[ENT_EOT_BIT];
  assign ent_in.len   = bus_wdata[ENT_LEN_LSB +: 4];
  assign ent_out      = tx_entry_t'(ent_raw);

  spi_sync_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(ent_in), .pop(tx_pop),
    .rdata(ent_raw), .count(tx_count), .full(tx_full), .empty(tx_empty));

  spi_sync_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty));

  spi_shift_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .cpha(cfg_cpha), .div(cfg_div),
    .ent_valid(!tx_empty), .ent(ent_out), .ent_pop(tx_pop), .sck(sck),
    .mosi(mosi), .miso(miso), .ssel_n(ssel_n), .busy(eng_busy),
    .done(eng_done), .rx_word(rx_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cpol <= 1'b0;
      cfg_cpha <= 1'b0;
      cfg_div  <= DIV_W'(DIV_RESET);
      cfg_txwm <= 4'd0;
      cfg_rxwm <= 4'd1;
      cfg_txen <= 1'b0;
      cfg_rxen <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (wr && bus_addr == OFF_CTRL) begin
        cfg_cpol <= bus_wdata[0];
        cfg_cpha <= bus_wdata[1];
        cfg_div  <= bus_wdata[8 +: DIV_W];
        cfg_txwm <= bus_wdata[19:16];
        cfg_rxwm <= bus_wdata[23:20];
        cfg_txen <= bus_wdata[24];
        cfg_rxen <= bus_wdata[25];
      end
      if (eng_done && rx_full) ovr <= 1'b1;
      else if (wr && bus_addr == OFF_STAT && bus_wdata[STAT_OVR]) ovr <= 1'b0;
    end
  end

  assign stat_txe = tx_empty && !eng_busy;
  assign irq_tx   = cfg_txen && (32'(tx_count) <= 32'(cfg_txwm));
  assign irq_rx   = cfg_rxen && (32'(rx_count) >= 32'(cfg_rxwm));

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[0] = cfg_cpol;
    ctrl_rd[1] = cfg_cpha;
    ctrl_rd[8 +: DIV_W] = cfg_div;
    ctrl_rd[19:16] = cfg_txwm;
    ctrl_rd[23:20] = cfg_rxwm;
    ctrl_rd[24] = cfg_txen;
    ctrl_rd[25] = cfg_rxen;
    stat_rd = '0;
    stat_rd[STAT_TXNF] = !tx_full;
    stat_rd[STAT_RXNE] = !rx_empty;
    stat_rd[STAT_OVR]  = ovr;
    stat_rd[STAT_TXE]  = stat_txe;
    case (bus_addr)
      OFF_CTRL: bus_rdata = ctrl_rd;
      OFF_STAT: bus_rdata = stat_rd;
      OFF_RXR:  bus_rdata = rx_empty ? 32'd0 : {16'd0, rx_head};
      default:  bus_rdata = 32'd0;
    endcase
  end

  assert_read_no_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !eng_busy && tx_empty && !tx_push) |=> !eng_busy);
  assert_txe_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_txe) |-> $past(eng_done));
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(wr && bus_addr == OFF_STAT)) |=> ovr);
  assert_full_write_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full && !tx_pop) |=> (tx_count == CW'(FIFO_DEPTH)));
endmodule

// File: tb/tb_spi_fifo_master.sv
`timescale 1ns/1ps
module tb_spi_fifo_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_tx, irq_rx, sck, mosi, miso;
  logic [3:0]  ssel_n;
  logic        inv = 1'b0;

  int tests = 0, fails = 0;
  bit finished = 0;

  localparam logic [11:0] A_CTRL = 12'hE00, A_STAT = 12'hE04,
                          A_TXW = 12'hE20, A_RXR = 12'hE30;

  always #10 clk = ~clk;
  assign miso = mosi ^ inv;

  spi_fifo_master dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .sck(sck), .mosi(mosi), .miso(miso),
    .ssel_n(ssel_n));

  // SCK monitor, sampled on the falling system clock edge
  int  cyc = 0, toggles = 0, last_t = 0, gap_min = 0, gap_max = 0;
  bit  have_t = 0;
  logic sck_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (sck !== sck_prev) begin
      toggles++;
      if (have_t) begin
        if (gap_min == 0 || cyc - last_t < gap_min) gap_min = cyc - last_t;
        if (cyc - last_t > gap_max) gap_max = cyc - last_t;
      end
      have_t = 1;
      last_t = cyc;
    end
    sck_prev = sck;
  end

  task automatic mon_clear();
    toggles = 0; have_t = 0; gap_min = 0; gap_max = 0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(bit cpol, bit cpha, int div, int txwm,
                                          int rxwm, bit txen, bit rxen);
    return {6'd0, rxen, txen, 4'(rxwm), 4'(txwm), 8'(div), 6'd0, cpha, cpol};
  endfunction

  function automatic logic [31:0] mk_ent(logic [15:0] d, int code, logic [3:0] desel, bit eot);
    return {4'd0, 4'(code), 3'd0, eot, desel, d};
  endfunction

  function automatic logic [31:0] exp_rx(logic [15:0] d, int code, bit invert);
    int n;
    logic [15:0] v;
    n = ((code < 3) ? 3 : code) + 1;
    v = invert ? ~d : d;
    return 32'(v & 16'((32'd1 << n) - 1));
  endfunction

  task automatic bus_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 40000; k++) begin
      bus_read(A_STAT, s);
      if (s[4]) break;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r, s;
    logic [15:0] d;
    int code, dv;
    bit cp, ch;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 sck", 32'(sck), 0);
    check("R1 ssel", 32'(ssel_n), 32'hF);
    bus_read(A_CTRL, r); check("R1 ctrl", r, 32'h0010_0100);
    bus_read(A_STAT, r); check("R1 status", r, 32'h12);

    // R2 R3 frame length, bit order and half period
    bus_write(A_CTRL, mk_ctrl(0, 0, 2, 0, 1, 0, 0));
    mon_clear();
    bus_write(A_TXW, mk_ent(16'h12A5, 7, 4'hE, 1));
    wait_idle();
    check("R2 toggles", 32'(toggles), 16);
    check("R2 gap min", 32'(gap_min), 3);
    check("R2 gap max", 32'(gap_max), 3);
    bus_read(A_RXR, r); check("R3 rx word", r, 32'h0000_00A5);

    // R4 reads never clock the bus; empty read gives zero
    mon_clear();
    for (int k = 0; k < 3; k++) begin
      bus_read(A_RXR, r); check("R4 empty read", r, 0);
    end
    repeat (4) @(negedge clk);
    check("R4 no sck", 32'(toggles), 0);

    // R12 short length code
    mon_clear();
    bus_write(A_TXW, mk_ent(16'hFFF9, 0, 4'hE, 1));
    wait_idle();
    check("R12 toggles", 32'(toggles), 8);
    bus_read(A_RXR, r); check("R12 rx", r, 32'h9);

    // R5 R6 select hold across entries and release on end flag
    bus_write(A_CTRL, mk_ctrl(0, 0, 1, 0, 1, 0, 0));
    bus_write(A_TXW, mk_ent(16'h0033, 7, 4'b1101, 0));
    repeat (3) @(negedge clk);
    check("R5 active line", 32'(ssel_n), 32'hD);
    wait_idle();
    check("R6 held", 32'(ssel_n), 32'hD);
    bus_write(A_TXW, mk_ent(16'h0044, 7, 4'b0111, 1));
    repeat (3) @(negedge clk);
    check("R5 second entry", 32'(ssel_n), 32'h7);
    wait_idle();
    check("R6 released", 32'(ssel_n), 32'hF);
    bus_read(A_RXR, r); check("R3 held frame", r, 32'h33);
    bus_read(A_RXR, r); check("R3 end frame", r, 32'h44);

    // R8 transmit-empty only after the frame completes
    bus_write(A_CTRL, mk_ctrl(0, 0, 3, 0, 1, 0, 0));
    bus_write(A_TXW, mk_ent(16'hBEEF, 15, 4'hE, 1));
    bus_read(A_STAT, r); check("R8 busy status", r & 32'h14, 0);
    wait_idle();
    bus_read(A_STAT, r); check("R8 done status", r & 32'h16, 32'h16);
    bus_read(A_RXR, r); check("R3 16-bit", r, 32'hBEEF);

    // R9 level interrupts
    check("R9 tx irq off", 32'(irq_tx), 0);
    bus_write(A_CTRL, mk_ctrl(0, 0, 0, 0, 2, 1, 1));
    check("R9 tx irq empty", 32'(irq_tx), 1);
    bus_write(A_TXW, mk_ent(16'h0001, 7, 4'hE, 1));
    wait_idle();
    check("R9 rx below wm", 32'(irq_rx), 0);
    bus_write(A_TXW, mk_ent(16'h0002, 7, 4'hE, 1));
    wait_idle();
    check("R9 rx at wm", 32'(irq_rx), 1);
    bus_read(A_RXR, r);
    bus_read(A_RXR, r);
    check("R9 rx drained", 32'(irq_rx), 0);

    // R10 overrun drops ninth word, sticky, write-1-clear
    bus_write(A_CTRL, mk_ctrl(0, 0, 0, 0, 1, 0, 0));
    for (int k = 0; k < 9; k++) bus_write(A_TXW, mk_ent(16'(8'h40 + k), 7, 4'hE, 1));
    wait_idle();
    bus_read(A_STAT, r); check("R10 overrun set", 32'(r[3]), 1);
    for (int k = 0; k < 8; k++) begin
      bus_read(A_RXR, r); check("R10 kept word", r, 32'(8'h40 + k));
    end
    bus_read(A_RXR, r); check("R10 dropped word", r, 0);
    bus_read(A_STAT, r); check("R10 still sticky", 32'(r[3]), 1);
    bus_write(A_STAT, 32'h8);
    bus_read(A_STAT, r); check("R10 cleared", 32'(r[3]), 0);

    // R11 writes to a full transmit FIFO are dropped
    bus_write(A_CTRL, mk_ctrl(0, 0, 255, 0, 1, 0, 0));
    mon_clear();
    for (int k = 0; k < 10; k++) bus_write(A_TXW, mk_ent(16'h5, 3, 4'hE, 1));
    bus_read(A_STAT, r); check("R11 not-full low", 32'(r[1]), 0);
    wait_idle();
    check("R11 frame count", 32'(toggles), 72);
    for (int k = 0; k < 8; k++) bus_read(A_RXR, r);
    bus_write(A_STAT, 32'h8);

    // rx push and rx pop in the same cycle
    bus_write(A_CTRL, mk_ctrl(0, 0, 1, 0, 1, 0, 0));
    bus_write(A_TXW, mk_ent(16'h0011, 7, 4'hE, 1));
    wait_idle();
    bus_write(A_TXW, mk_ent(16'h0022, 7, 4'hE, 1));
    repeat (31) @(negedge clk);
    bus_read(A_RXR, r); check("R4 collide old word", r, 32'h11);
    wait_idle();
    bus_read(A_RXR, r); check("R3 collide new word", r, 32'h22);
    bus_read(A_RXR, r); check("R4 collide empty", r, 0);
    bus_read(A_STAT, r); check("R10 collide no overrun", 32'(r[3]), 0);

    // R7 idle level
    bus_write(A_CTRL, mk_ctrl(1, 1, 1, 0, 1, 0, 0));
    @(negedge clk);
    check("R7 idle high", 32'(sck), 1);

    // random modes, lengths, data and MISO polarity
    for (int it = 0; it < 30; it++) begin
      cp   = 1'($urandom_range(0, 1));
      ch   = 1'($urandom_range(0, 1));
      dv   = $urandom_range(0, 3);
      code = $urandom_range(0, 15);
      d    = 16'($urandom);
      inv  = 1'($urandom_range(0, 1));
      bus_write(A_CTRL, mk_ctrl(cp, ch, dv, 0, 1, 0, 0));
      @(negedge clk);
      check("R7 idle level", 32'(sck), 32'(cp));
      mon_clear();
      bus_write(A_TXW, mk_ent(d, code, 4'(~(4'h1 << (it % 4))), 1));
      wait_idle();
      check("R2 random toggles", 32'(toggles), 32'(2 * (((code < 3) ? 3 : code) + 1)));
      bus_read(A_RXR, r); check("R3 random rx", r, exp_rx(d, code, inv));
      check("R6 random release", 32'(ssel_n), 32'hF);
    end
    inv = 0;
    bus_read(A_STAT, s); check("R8 final status", s & 32'h1E, 32'h12);
    finish_run();
  end
endmodule